// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single memory requests from a small microcontroller core into cycles on a multiplexed external address/data bus. A request carries a 24-bit address, a direction and a write byte. For an external access the block drives one address-latch state that puts the low address byte on the shared bus and the upper 16 bits on a separate address port. It then drives a read or write strobe for one state plus the wait states of the target region. One clock after the strobe ends it returns the read byte with a single-cycle done pulse.

Three static settings shape the cycles. The first is a 2-bit wait code for address region 01 (bits 23:16 equal to 01h). The second is an active-low enable for extended data float timing. The third is a remap switch that can serve the external window 00:E000h–00:FFFFh from on-chip code memory at FF:2000h–FF:3FFFh. A request flagged as a configuration fetch always runs on the external bus with extended float timing, whatever the settings say. The sequencer counts time in whole clock states.

Top module: `ext_bus_timer`

## Requirements
- R1: With legacy timing, a region 01 access holds its strobe for 1 + W states, where W is 3, 2, 1 and 0 for wait codes 00, 01, 10 and 11.
- R2: With extended timing, region 01 wait codes 00 and 01 give W = 3 and codes 10 and 11 give W = 1, so W is never 0 or 2.
- R3: The float control input is active low: 0 selects extended timing and 1 selects legacy timing.
- R4: After an extended-timing read, the cycle after the strobe is an idle state in which the bus output enable is 0, ALE is 0 and ready is 0. Ready returns the cycle after that. Legacy reads and all writes have no such state.
- R5: A request with the configuration-fetch flag set uses extended timing even when the float input is 1, and it is never remapped.
- R6: When the remap input is 0, an access to 00:E000h–00:FFFFh drives code_en in the request cycle with code_addr = FF:2000h plus the offset, then completes with done in the next cycle, with no ALE and no strobe. The read byte is code_rdata. When the remap input is 1, or the address is outside the window, the access goes to the external bus.
- R7: Done is high for exactly one clock per access. On an external access it comes W + 3 cycles after the request edge, one cycle after the last strobe state. For a read, rsp_rdata then holds the bus byte sampled in the last strobe state.
- R8: Each external access has exactly one ALE state, in the cycle after acceptance. In that state bus_ad_out holds address bits 7:0, bus_addr_hi holds bits 23:8 and the output enable is 1.
- R9: During a write strobe, wr_n is 0, rd_n is 1, the output enable is 1 and bus_ad_out holds the write byte. During a read strobe, rd_n is 0, wr_n is 1 and the output enable is 0. The two strobes are never low together.
- R10: External accesses outside region 01 take zero wait states (W = 0).
- R11: After reset, ALE and done are 0, both strobes are 1, the output enable is 0 and ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when ready is 1 |
| req_addr | input | 24 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| req_cfg_fetch | input | 1 | Configuration-fetch cycle flag |
| cfg_r01_wait | input | 2 | Wait code for region 01 |
| cfg_float_n | input | 1 | 0 = extended data float timing, 1 = legacy |
| cfg_remap_off | input | 1 | 0 = serve window from on-chip code, 1 = external |
| ready | output | 1 | Sequencer idle and able to take a request |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with done |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ad_out | output | 8 | Multiplexed address/data output |
| bus_ad_oe | output | 1 | Output enable of the multiplexed bus |
| bus_ad_in | input | 8 | Multiplexed bus input |
| bus_addr_hi | output | 16 | Upper address bits 23:8 |
| code_en | output | 1 | On-chip code read enable for remapped accesses |
| code_addr | output | 24 | Translated on-chip code address |
| code_rdata | input | 8 | On-chip code data, one cycle after code_en |

## Verification
The assertions assume that the configuration inputs do not change while a cycle is in flight. They also assume that code_rdata answers one clock after code_en and that bus_ad_in settles within the strobe state in which it is sampled. The bench only changes settings at falling edges while ready is high and only raises req_valid for one cycle at such an edge. It models the on-chip code memory as a one-cycle registered lookup and drives bus_ad_in as a fixed function of the held upper address, so the sampled byte is known at any point in the strobe.

// File: rtl/ebt_pkg.sv
package ebt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_STRB  = 2'd2,
    ST_FLOAT = 2'd3
  } ebt_state_t;

  // Region 01 wait count: extended timing allows only 1 or 3 states.
  function automatic logic [1:0] region_waits(input logic [1:0] code, input logic ext);
    if (ext) return code[1] ? 2'd1 : 2'd3;
    else     return 2'd3 - code;
  endfunction

endpackage

// File: rtl/ebt_decode.sv
module ebt_decode #(
  parameter int          ADDR_W    = 24,
  parameter int          REGION_W  = 8,
  parameter int          WIN_LOG2  = 13,
  parameter logic [23:0] WIN_BASE  = 24'h00E000,
  parameter logic [23:0] MAP_BASE  = 24'hFF2000,
  parameter logic [7:0]  SLOW_REG  = 8'h01
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetch,
  input  logic [1:0]        wait_code,
  input  logic              float_n,
  input  logic              remap_off,
  output logic              is_int,
  output logic              is_r01,
  output logic              ext_mode,
  output logic [1:0]        waits,
  output logic [ADDR_W-1:0] map_addr
);
  import ebt_pkg::*;

  localparam int TAG_W = ADDR_W - WIN_LOG2;

  logic [REGION_W-1:0] region;
  logic                win_hit;

  always_comb begin
    region   = addr[ADDR_W-1 -: REGION_W];
    win_hit  = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1 -: TAG_W]);
    is_int   = win_hit && !remap_off && !fetch;
    ext_mode = fetch || !float_n;
    is_r01   = (region == SLOW_REG[REGION_W-1:0]);
    waits    = is_r01 ? region_waits(wait_code, ext_mode) : 2'd0;
    map_addr = {MAP_BASE[ADDR_W-1 -: TAG_W], addr[WIN_LOG2-1:0]};
  end

endmodule

// File: rtl/ebt_seq.sv
module ebt_seq #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     dec_int,
  input  logic                     dec_r01,
  input  logic                     dec_ext,
  input  logic [WAIT_W-1:0]        dec_waits,
  output logic                     ready,
  output logic                     accept,
  output logic                     done,
  output logic                     int_sel,
  output logic [DATA_W-1:0]        rdata,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi
);
  import ebt_pkg::*;

  ebt_state_t        state;
  logic [WAIT_W-1:0] cnt;
  logic              wr_q;
  logic              ext_q;
  logic [DATA_W-1:0] wdata_q;

  assign ready  = (state == ST_IDLE);
  assign accept = req_valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      ext_q   <= 1'b0;
      wdata_q <= '0;
      done    <= 1'b0;
      int_sel <= 1'b0;
      rdata   <= '0;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      addr_hi <= '0;
    end else begin
      done <= 1'b0;
      ale  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          ad_oe <= 1'b0;
          if (accept) begin
            if (dec_int) begin
              done    <= 1'b1;
              int_sel <= 1'b1;
            end else begin
              int_sel <= 1'b0;
              ale     <= 1'b1;
              ad_oe   <= 1'b1;
              ad_out  <= req_addr[DATA_W-1:0];
              addr_hi <= req_addr[ADDR_W-1:DATA_W];
              wr_q    <= req_write;
              wdata_q <= req_wdata;
              ext_q   <= dec_ext;
              cnt     <= dec_waits;
              state   <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          state <= ST_STRB;
          if (wr_q) begin
            wr_n   <= 1'b0;
            ad_out <= wdata_q;
            ad_oe  <= 1'b1;
          end else begin
            rd_n  <= 1'b0;
            ad_oe <= 1'b0;
          end
        end
        ST_STRB: begin
          if (cnt == '0) begin
            rd_n  <= 1'b1;
            wr_n  <= 1'b1;
            ad_oe <= 1'b0;
            done  <= 1'b1;
            if (!wr_q) rdata <= ad_in;
            state <= (ext_q && !wr_q) ? ST_FLOAT : ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Both strobes never low together.
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // The address state is always followed by a strobe.
  p_ale_then_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!ale && (!rd_n || !wr_n)));

  // Done appears in the cycle a strobe is released.
  p_done_on_release_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_n) || $rose(wr_n)) |-> done);

  // Extended read leaves one released, non-ready state before the next address.
  p_float_gap_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_n) && ext_q) |-> (!ad_oe && !ale && !ready));

  // Remapped completions are silent on the bus.
  p_remap_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (done && int_sel) |-> (rd_n && wr_n && !ale));

  // Extended region 01 accesses get an odd wait count only.
  p_wait_odd_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && !dec_int && dec_ext && dec_r01) |-> dec_waits[0]);

endmodule

// File: rtl/ext_bus_timer.sv
module ext_bus_timer #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_cfg_fetch,
  input  logic [1:0]               cfg_r01_wait,
  input  logic                     cfg_float_n,
  input  logic                     cfg_remap_off,
  output logic                     ready,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     bus_ale,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_in,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic                     code_en,
  output logic [ADDR_W-1:0]        code_addr,
  input  logic [DATA_W-1:0]        code_rdata
);
  localparam int WAIT_W = 2;

  logic              d_int, d_r01, d_ext;
  logic [WAIT_W-1:0] d_waits;
  logic              accept, int_sel;
  logic [DATA_W-1:0] ext_rdata;

  ebt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (req_addr),
    .fetch     (req_cfg_fetch),
    .wait_code (cfg_r01_wait),
    .float_n   (cfg_float_n),
    .remap_off (cfg_remap_off),
    .is_int    (d_int),
    .is_r01    (d_r01),
    .ext_mode  (d_ext),
    .waits     (d_waits),
    .map_addr  (code_addr)
  );

  ebt_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .dec_int   (d_int),
    .dec_r01   (d_r01),
    .dec_ext   (d_ext),
    .dec_waits (d_waits),
    .ready     (ready),
    .accept    (accept),
    .done      (rsp_done),
    .int_sel   (int_sel),
    .rdata     (ext_rdata),
    .ale       (bus_ale),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .ad_out    (bus_ad_out),
    .ad_oe     (bus_ad_oe),
    .ad_in     (bus_ad_in),
    .addr_hi   (bus_addr_hi)
  );

  assign code_en   = accept && d_int;
  assign rsp_rdata = int_sel ? code_rdata : ext_rdata;

endmodule

// File: tb/sim_ext_bus_timer.sv
`timescale 1ns/1ps
module sim_ext_bus_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        req_cfg_fetch = 1'b0;
  logic [1:0]  cfg_r01_wait = '0;
  logic        cfg_float_n = 1'b1;
  logic        cfg_remap_off = 1'b1;
  logic        ready, rsp_done, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, code_en;
  logic [7:0]  rsp_rdata, bus_ad_out, bus_ad_in;
  logic [15:0] bus_addr_hi;
  logic [23:0] code_addr;
  logic [7:0]  code_q = '0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ext_bus_timer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_cfg_fetch(req_cfg_fetch),
    .cfg_r01_wait(cfg_r01_wait), .cfg_float_n(cfg_float_n), .cfg_remap_off(cfg_remap_off),
    .ready(ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_ale(bus_ale),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_addr_hi(bus_addr_hi),
    .code_en(code_en), .code_addr(code_addr), .code_rdata(code_q)
  );

  // External device: byte is a fixed function of the held upper address.
  assign bus_ad_in = bus_addr_hi[7:0] ^ 8'h5A;
  // On-chip code model: one-cycle registered lookup.
  always @(posedge clk) if (code_en) code_q <= code_addr[7:0] ^ 8'hC3;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [23:0] a, input bit wr, input logic [7:0] wd,
                        input bit fetch, input bit exp_int, input int exp_w,
                        input bit exp_float, input string tag);
    int ale_n = 0, strb = 0, dn = 0, done_at = -1;
    req_addr = a; req_write = wr; req_wdata = wd; req_cfg_fetch = fetch; req_valid = 1'b1;
    #1;
    if (exp_int) chk(code_en && code_addr == {11'h7F9, a[12:0]}, {"R6 code_addr ", tag},
                     code_addr, {11'h7F9, a[12:0]});
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= 12; c++) begin
      if (bus_ale) begin
        ale_n++;
        chk(bus_ad_out == a[7:0] && bus_addr_hi == a[23:8] && bus_ad_oe, {"R8 addr phase ", tag},
            {bus_addr_hi, bus_ad_out}, a);
      end
      if (!bus_rd_n || !bus_wr_n) begin
        strb++;
        if (wr) chk(!bus_wr_n && bus_rd_n && bus_ad_oe && bus_ad_out == wd, {"R9 write strobe ", tag},
                    {bus_rd_n, bus_wr_n, bus_ad_oe, bus_ad_out}, {3'b101, wd});
        else    chk(!bus_rd_n && bus_wr_n && !bus_ad_oe, {"R9 read strobe ", tag},
                    {bus_rd_n, bus_wr_n, bus_ad_oe}, 3'b010);
      end
      if (rsp_done) begin
        dn++;
        done_at = c;
        if (!wr) begin
          if (exp_int) chk(rsp_rdata == (a[7:0] ^ 8'hC3), {"R6 code data ", tag}, rsp_rdata, a[7:0] ^ 8'hC3);
          else         chk(rsp_rdata == (a[15:8] ^ 8'h5A), {"R7 bus data ", tag}, rsp_rdata, a[15:8] ^ 8'h5A);
        end
        if (exp_float) chk(!ready && !bus_ad_oe && !bus_ale, {"R4 float state ", tag},
                           {ready, bus_ad_oe, bus_ale}, 3'b000);
        else           chk(ready, {"R4 no float state ", tag}, ready, 1);
      end
      if (exp_float && done_at > 0 && c == done_at + 1)
        chk(ready, {"R4 ready after float ", tag}, ready, 1);
      @(negedge clk);
    end
    chk(dn == 1, {"R7 done count ", tag}, dn, 1);
    if (exp_int) begin
      chk(ale_n == 0 && strb == 0, {"R6 no bus activity ", tag}, {ale_n[15:0], strb[15:0]}, 0);
      chk(done_at == 1, {"R6 done cycle ", tag}, done_at, 1);
    end else begin
      chk(ale_n == 1, {"R8 ale count ", tag}, ale_n, 1);
      chk(strb == exp_w + 1, {"R1 R2 R10 strobe length ", tag}, strb, exp_w + 1);
      chk(done_at == exp_w + 3, {"R7 done cycle ", tag}, done_at, exp_w + 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && !rsp_done && ready, "R11 reset state",
        {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, rsp_done, ready}, 6'b011001);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && !rsp_done && ready, "R11 after release",
        {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, rsp_done, ready}, 6'b011001);

    // Sweep: float bit x wait code x direction x fetch flag x region.
    cfg_remap_off = 1'b1;
    for (int f = 0; f < 2; f++)
      for (int code = 0; code < 4; code++)
        for (int wr = 0; wr < 2; wr++)
          for (int fe = 0; fe < 2; fe++)
            for (int rg = 1; rg < 3; rg++) begin
              bit ext;
              int w;
              logic [23:0] a;
              cfg_float_n  = f[0];
              cfg_r01_wait = code[1:0];
              ext = (fe == 1) || (f == 0);           // R3, R5
              if (rg == 1) w = ext ? (code >= 2 ? 1 : 3) : 3 - code;  // R1, R2
              else         w = 0;                     // R10
              a = {rg[7:0], 4'hA, code[1:0], wr[0], fe[0], 7'h2C, f[0]};
              access(a, wr[0], 8'h96 ^ a[7:0], fe[0], 1'b0, w, ext && (wr == 0),
                     $sformatf("f=%0d code=%0d wr=%0d fetch=%0d rg=%0d", f, code, wr, fe, rg));
            end

    // Remap window cases (R6), legacy timing.
    cfg_float_n = 1'b1; cfg_r01_wait = 2'b00;
    cfg_remap_off = 1'b0;
    access(24'h00E000, 1'b0, 8'h00, 1'b0, 1'b1, 0, 1'b0, "R6 win low");
    access(24'h00FFFF, 1'b0, 8'h00, 1'b0, 1'b1, 0, 1'b0, "R6 win high");
    access(24'h00F3A7, 1'b0, 8'h00, 1'b0, 1'b1, 0, 1'b0, "R6 win mid");
    access(24'h00E455, 1'b1, 8'h3E, 1'b0, 1'b1, 0, 1'b0, "R6 win write");
    access(24'h00DFFF, 1'b0, 8'h00, 1'b0, 1'b0, 0, 1'b0, "R6 below window");
    access(24'h01E000, 1'b0, 8'h00, 1'b0, 1'b0, 3, 1'b0, "R6 region01 not window");
    access(24'h00E010, 1'b0, 8'h00, 1'b1, 1'b0, 0, 1'b1, "R5 fetch not remapped");
    cfg_remap_off = 1'b1;
    access(24'h00E000, 1'b0, 8'h00, 1'b0, 1'b0, 0, 1'b0, "R6 remap off");
    cfg_float_n = 1'b0;
    access(24'h00FFFE, 1'b0, 8'h00, 1'b0, 1'b0, 0, 1'b1, "R6 remap off extended");

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule